// File: doc/BRIEF.md
# Triggered Memory Transfer Controller

A single-channel transfer engine that copies bytes between two address pointers over a byte-wide master port. Software programs a mode, two pointers, a transfer count and a start-source select while the engine is idle. One event starts each job. The event is either the selected hardware trigger line or a software start pulse. The engine then runs one or more byte moves. Each move is a read bus cycle followed by a write bus cycle, and each bus cycle is stretched until the slave returns ready.

The 4-bit mode picks the direction of each byte, the number of bytes per job and the pointer update rule. Pointer 1 can address either the full address space or a 256-byte I/O window. In the window, only the low pointer byte is kept and the upper address bits are forced to the window base. Some modes move two bytes per job, either as a word or as an inbound/outbound pair. Modes E and F are count-driven bursts. When the final byte of a job has been written, the engine gives a one-cycle done pulse and returns to idle.

Top module: `trig_xfer_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, bus_rd_o and bus_wr_o are low.
- R2: A job starts on sw_start_i. It also starts on trig_i[cfg_sel_i] when cfg_sel_i is below 12. A select value of 12 to 15 disables every hardware line. A start event that arrives while busy_o is high is ignored.
- R3: Each byte move asserts bus_rd_o with the source address until bus_ready_i is high, and the read data is captured. The next cycle asserts bus_wr_o with the destination address and the captured data until bus_ready_i is high. bus_rd_o and bus_wr_o are never high together.
- R4: The I/O-window address is {8'hFF, ptr1[7:0]}. Modes 0 and 2 move one byte from ptr0 to the window, and modes 1 and 3 move one byte from the window to ptr0. Modes 2 and 3 then add 1 to ptr0, and modes 0 and 1 leave both pointers unchanged.
- R5: Modes 4 (ptr0 to window) and 5 (window to ptr0) move two bytes. The first uses window address ptr1 and the second uses ptr1 with bit 0 set. ptr0 is incremented after each byte, so the second byte uses the incremented ptr0.
- R6: Modes 6 to 9 move two bytes. The first goes from the window to ptr0, and ptr0 is then incremented. The second goes from the updated ptr0 to the window. In modes 8 and 9 the second byte uses window address bit 0 set. Modes 6 and 8 increment ptr0 again after the second byte, and modes 7 and 9 do not.
- R7: Modes A (ptr0 to ptr1) and B (ptr1 to ptr0) move one byte with full 16-bit addresses and no pointer change. Modes C and D move two bytes in the same directions and increment both pointers after each byte.
- R8: Modes E (ptr0 to ptr1) and F (ptr1 to ptr0) use full addresses. After each byte they increment both pointers and decrement the count, and they stop after the byte that brings the count to 0. With a count of 0 at start they make no bus cycle and only signal done.
- R9: done_o is high for exactly the one cycle after the final write is accepted, and in that same cycle busy_o is already low.
- R10: A configuration write (cfg_we_i) is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load all configuration fields |
| cfg_mode_i | input | 4 | Transfer mode 0..F |
| cfg_ptr0_i | input | 16 | Initial pointer 0 |
| cfg_ptr1_i | input | 16 | Initial pointer 1 |
| cfg_count_i | input | 8 | Burst byte count |
| cfg_sel_i | input | 4 | Hardware trigger select |
| trig_i | input | 12 | Hardware trigger lines |
| sw_start_i | input | 1 | Software start pulse |
| bus_addr_o | output | 16 | Master address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data |
| bus_ready_i | input | 1 | Slave ready, ends the current cycle |
| ptr0_o | output | 16 | Current pointer 0 |
| ptr1_o | output | 16 | Current pointer 1 |
| count_o | output | 8 | Current transfer count |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |

## Verification
The start event is sampled at a clock edge, and the first read strobe appears in the cycle after it. Each strobe moves on in the cycle after the edge that sees ready. The done pulse, the cleared busy flag and the final pointer values appear one cycle after the last write is accepted. For a zero-count burst they appear one cycle after the start. The bench drives ready from a pseudo-random pattern. At each falling edge it matches an access that is about to be accepted against the next expected item in its queue. It checks done one falling edge after the last item and reads pointers and count once busy has dropped.

// File: rtl/txe_pkg.sv
package txe_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_st_e;

  typedef struct packed {
    logic src_p1;   // source is the pointer-1 side
    logic io_win;   // pointer-1 side goes through the I/O window
    logic io_odd;   // force window address bit 0
    logic inc_p0;
    logic inc_p1;
    logic last;     // final byte of a fixed-length job
    logic burst;    // length taken from the count register
  } step_ctl_t;

  localparam logic [3:0] M_PAIR_LO = 4'h6;
  localparam logic [3:0] M_PAIR_HI = 4'h9;
endpackage

// File: rtl/txe_step_decode.sv
module txe_step_decode
  import txe_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       step_i,
  output step_ctl_t  ctl_o
);
  always_comb begin
    ctl_o        = '0;
    ctl_o.src_p1 = mode_i[0];
    unique case (mode_i)
      4'h0, 4'h1: begin
        ctl_o.io_win = 1'b1;
        ctl_o.last   = 1'b1;
      end
      4'h2, 4'h3: begin
        ctl_o.io_win = 1'b1;
        ctl_o.inc_p0 = 1'b1;
        ctl_o.last   = 1'b1;
      end
      4'h4, 4'h5: begin
        ctl_o.io_win = 1'b1;
        ctl_o.io_odd = step_i;
        ctl_o.inc_p0 = 1'b1;
        ctl_o.last   = step_i;
      end
      4'h6, 4'h7, 4'h8, 4'h9: begin
        // inbound byte first, outbound byte second
        ctl_o.io_win = 1'b1;
        ctl_o.src_p1 = ~step_i;
        ctl_o.io_odd = step_i & mode_i[3];
        ctl_o.inc_p0 = ~step_i | ~mode_i[0];
        ctl_o.last   = step_i;
      end
      4'hA, 4'hB: ctl_o.last = 1'b1;
      4'hC, 4'hD: begin
        ctl_o.inc_p0 = 1'b1;
        ctl_o.inc_p1 = 1'b1;
        ctl_o.last   = step_i;
      end
      default: begin
        ctl_o.inc_p0 = 1'b1;
        ctl_o.inc_p1 = 1'b1;
        ctl_o.burst  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/txe_trig_sel.sv
module txe_trig_sel #(
  parameter int NUM_TRIG = 12,
  parameter int SEL_W    = 4
) (
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                sw_start_i,
  output logic                start_o
);
  logic hw_hit;

  always_comb begin
    hw_hit = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (sel_i == SEL_W'(i)) hw_hit = trig_i[i];
  end

  assign start_o = sw_start_i | hw_hit;
endmodule

// File: rtl/txe_bus_seq.sv
module txe_bus_seq
  import txe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              empty_job_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              step_o,
  output logic              step_done_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_st_e           st_q;
  logic [DATA_W-1:0] data_q;
  logic              step_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      step_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          step_q <= 1'b0;
          if (empty_job_i) done_q <= 1'b1;
          else             st_q   <= ST_RD;
        end
        ST_RD: if (ready_i) begin
          data_q <= rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (ready_i) begin
          if (last_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q   <= ST_RD;
            step_q <= ~step_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o        = (st_q == ST_RD);
  assign wr_o        = (st_q == ST_WR);
  assign addr_o      = wr_o ? dst_addr_i : src_addr_i;
  assign wdata_o     = data_q;
  assign step_o      = step_q;
  assign step_done_o = wr_o & ready_i;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_hold_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && !ready_i |=> rd_o && $stable(addr_o));
  p_hold_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && !ready_i |=> wr_o && $stable(addr_o) && $stable(wdata_o));
  p_rd_then_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && ready_i |=> wr_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/trig_xfer_engine.sv
module trig_xfer_engine
  import txe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int IO_LO_W  = 8,
  parameter int NUM_TRIG = 12,
  parameter int SEL_W    = 4,
  parameter logic [ADDR_W-IO_LO_W-1:0] IO_BASE_HI = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [3:0]          cfg_mode_i,
  input  logic [ADDR_W-1:0]   cfg_ptr0_i,
  input  logic [ADDR_W-1:0]   cfg_ptr1_i,
  input  logic [CNT_W-1:0]    cfg_count_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                sw_start_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                bus_rd_o,
  output logic                bus_wr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  input  logic                bus_ready_i,
  output logic [ADDR_W-1:0]   ptr0_o,
  output logic [ADDR_W-1:0]   ptr1_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                busy_o,
  output logic                done_o
);
  logic [3:0]        mode_q;
  logic [ADDR_W-1:0] ptr0_q, ptr1_q;
  logic [CNT_W-1:0]  count_q;
  logic [SEL_W-1:0]  sel_q;

  step_ctl_t         ctl;
  logic              step, step_done, busy, start_req, last, empty_job;
  logic [ADDR_W-1:0] p1_addr, src_addr, dst_addr;

  txe_trig_sel #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_trig (
    .trig_i     (trig_i),
    .sel_i      (sel_q),
    .sw_start_i (sw_start_i),
    .start_o    (start_req)
  );

  txe_step_decode u_dec (
    .mode_i (mode_q),
    .step_i (step),
    .ctl_o  (ctl)
  );

  assign p1_addr   = ctl.io_win
                   ? {IO_BASE_HI, ptr1_q[IO_LO_W-1:1], ptr1_q[0] | ctl.io_odd}
                   : ptr1_q;
  assign src_addr  = ctl.src_p1 ? p1_addr : ptr0_q;
  assign dst_addr  = ctl.src_p1 ? ptr0_q  : p1_addr;
  assign last      = ctl.burst ? (count_q == CNT_W'(1)) : ctl.last;
  assign empty_job = ctl.burst && (count_q == '0);

  txe_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_req),
    .empty_job_i (empty_job),
    .last_i      (last),
    .src_addr_i  (src_addr),
    .dst_addr_i  (dst_addr),
    .ready_i     (bus_ready_i),
    .rdata_i     (bus_rdata_i),
    .addr_o      (bus_addr_o),
    .rd_o        (bus_rd_o),
    .wr_o        (bus_wr_o),
    .wdata_o     (bus_wdata_o),
    .step_o      (step),
    .step_done_o (step_done),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ptr0_q  <= '0;
      ptr1_q  <= '0;
      count_q <= '0;
      sel_q   <= '1;
    end else if (cfg_we_i && !busy) begin
      mode_q  <= cfg_mode_i;
      ptr0_q  <= cfg_ptr0_i;
      ptr1_q  <= cfg_ptr1_i;
      count_q <= cfg_count_i;
      sel_q   <= cfg_sel_i;
    end else if (step_done) begin
      if (ctl.inc_p0) ptr0_q  <= ptr0_q + 1'b1;
      if (ctl.inc_p1) ptr1_q  <= ptr1_q + 1'b1;
      if (ctl.burst)  count_q <= count_q - 1'b1;
    end
  end

  assign ptr0_o  = ptr0_q;
  assign ptr1_o  = ptr1_q;
  assign count_o = count_q;
  assign busy_o  = busy;

  p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !step_done |=> $stable(ptr0_q) && $stable(ptr1_q) && $stable(mode_q));
  p_burst_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done && ctl.burst |=> count_q == $past(count_q) - 1'b1);
  p_io_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && mode_q < 4'hA && mode_q[0] && !(mode_q >= M_PAIR_LO && mode_q <= M_PAIR_HI && step)
    |-> bus_addr_o[ADDR_W-1:IO_LO_W] == IO_BASE_HI);
endmodule

// File: tb/trig_xfer_engine_test.sv
module trig_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic [15:0] cfg_ptr0 = '0, cfg_ptr1 = '0;
  logic [7:0]  cfg_count = '0;
  logic [3:0]  cfg_sel = 4'hF;
  logic [11:0] trig = '0;
  logic        sw_start = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ready = 1'b0;
  logic [15:0] ptr0, ptr1;
  logic [7:0]  count;
  logic        busy, done;

  int checks = 0;
  int failures = 0;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    bit          last;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  bit   done_due = 0;
  bit   zero_ok = 0;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  trig_xfer_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_ptr0_i(cfg_ptr0), .cfg_ptr1_i(cfg_ptr1), .cfg_count_i(cfg_count),
    .cfg_sel_i(cfg_sel), .trig_i(trig), .sw_start_i(sw_start),
    .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .ptr0_o(ptr0), .ptr1_o(ptr1), .count_o(count), .busy_o(busy), .done_o(done)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / responder / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_ready = lfsr[0] | lfsr[3];
      if (done_due) begin
        chk(done && !busy, "R9", "done pulse after last write", {done, busy}, 2'b10);
        done_due = 0;
      end else if (done && !zero_ok) begin
        chk(0, "R9", "unexpected done", done, 0);
      end
      if ((bus_rd || bus_wr) && bus_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2", "access with no job pending", bus_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(bus_wr == e.wr && !(bus_rd && bus_wr), "R3", "access kind", bus_wr, e.wr);
          chk(bus_addr == e.addr, e.req, "access address", bus_addr, e.addr);
          if (e.wr) chk(bus_wdata == e.data, "R3", "write data", bus_wdata, e.data);
          if (e.wr && e.last) done_due = 1;
        end
      end
    end
  end

  task automatic push_byte(logic [15:0] src, logic [15:0] dst, bit last, string req);
    exp_t e;
    e.wr = 0; e.addr = src; e.data = mem_val(src); e.last = 0; e.req = req;
    exp_q.push_back(e);
    e.wr = 1; e.addr = dst; e.last = last;
    exp_q.push_back(e);
  endtask

  function automatic logic [15:0] io_a(logic [15:0] p, bit odd);
    return {8'hFF, p[7:1], p[0] | odd};
  endfunction

  function automatic string req_of(logic [3:0] m);
    if (m < 4)  return "R4";
    if (m < 6)  return "R5";
    if (m < 10) return "R6";
    if (m < 14) return "R7";
    return "R8";
  endfunction

  // independent model: queues expected accesses and returns final state
  task automatic model(logic [3:0] m, inout logic [15:0] p0, inout logic [15:0] p1,
                       inout logic [7:0] c);
    string r = req_of(m);
    case (m)
      4'h0: push_byte(p0, io_a(p1, 0), 1, r);
      4'h1: push_byte(io_a(p1, 0), p0, 1, r);
      4'h2: begin push_byte(p0, io_a(p1, 0), 1, r); p0++; end
      4'h3: begin push_byte(io_a(p1, 0), p0, 1, r); p0++; end
      4'h4, 4'h5: for (int k = 0; k < 2; k++) begin
        if (m == 4'h4) push_byte(p0, io_a(p1, k[0]), k == 1, r);
        else           push_byte(io_a(p1, k[0]), p0, k == 1, r);
        p0++;
      end
      4'h6, 4'h7, 4'h8, 4'h9: begin
        push_byte(io_a(p1, 0), p0, 0, r);
        p0++;
        push_byte(p0, io_a(p1, m >= 8), 1, r);
        if (m == 4'h6 || m == 4'h8) p0++;
      end
      4'hA: push_byte(p0, p1, 1, r);
      4'hB: push_byte(p1, p0, 1, r);
      4'hC, 4'hD: for (int k = 0; k < 2; k++) begin
        if (m == 4'hC) push_byte(p0, p1, k == 1, r);
        else           push_byte(p1, p0, k == 1, r);
        p0++; p1++;
      end
      default: while (c != 0) begin
        if (m == 4'hE) push_byte(p0, p1, c == 1, r);
        else           push_byte(p1, p0, c == 1, r);
        p0++; p1++; c--;
      end
    endcase
  endtask

  task automatic configure(logic [3:0] m, logic [15:0] p0, logic [15:0] p1,
                           logic [7:0] c, logic [3:0] sel);
    cfg_mode = m; cfg_ptr0 = p0; cfg_ptr1 = p1; cfg_count = c; cfg_sel = sel;
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // hw_idx < 0 uses software start; meddle injects start/config while busy
  task automatic run_job(logic [3:0] m, logic [15:0] p0, logic [15:0] p1,
                         logic [7:0] c, logic [3:0] sel, int hw_idx, bit meddle);
    logic [15:0] e0 = p0, e1 = p1;
    logic [7:0]  ec = c;
    bit zero = (m >= 4'hE) && (c == 0);
    string r = req_of(m);
    configure(m, p0, p1, c, sel);
    model(m, e0, e1, ec);
    zero_ok = zero;
    if (hw_idx < 0) sw_start = 1; else trig[hw_idx] = 1;
    @(negedge clk);
    sw_start = 0; trig = '0;
    if (zero) begin
      chk(done && !busy, "R8", "zero-count burst done", {done, busy}, 2'b10);
      @(negedge clk);
      zero_ok = 0;
    end else begin
      chk(busy, "R2", "busy after start", busy, 1);
      if (meddle) begin
        repeat (3) @(negedge clk);
        chk(busy, "R10", "still busy before meddling", busy, 1);
        sw_start = 1; trig = '1;
        cfg_ptr0 = 16'hDEAD; cfg_ptr1 = 16'hBEEF; cfg_mode = 4'h0; cfg_we = 1;
        @(negedge clk);
        sw_start = 0; trig = '0; cfg_we = 0;
      end
      while (busy) @(negedge clk);
    end
    chk(exp_q.size() == 0, r, "all accesses seen", exp_q.size(), 0);
    chk(ptr0 == e0, r, "final ptr0", ptr0, e0);
    chk(ptr1 == e1, r, "final ptr1", ptr1, e1);
    chk(count == ec, r, "final count", count, ec);
    repeat (4) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R2", "no restart after job", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr, "R1", "reset state",
        {busy, done, bus_rd, bus_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R1", "idle after release", {busy, bus_rd, bus_wr}, 0);

    for (int m = 0; m < 16; m++)
      run_job(m[3:0], 16'h0230 + 16'(m * 16), 16'h1A40 + 16'(m * 2), 8'd3, 4'hF, -1, 0);
    run_job(4'hE, 16'h4000, 16'h80FE, 8'd6, 4'hF, -1, 0);
    run_job(4'hF, 16'h0100, 16'h0200, 8'd1, 4'hF, -1, 0);
    run_job(4'hE, 16'h5000, 16'h6000, 8'd0, 4'hF, -1, 0);   // R8 zero count
    run_job(4'h4, 16'h00FF, 16'h33C6, 8'd0, 4'hF, -1, 0);   // R5 carry in ptr0
    run_job(4'h2, 16'h0700, 16'h0010, 8'd0, 4'd7, 7, 0);    // R2 hw trigger
    run_job(4'h9, 16'h0900, 16'h0022, 8'd0, 4'd0, 0, 0);    // R2 trigger line 0
    run_job(4'hE, 16'h7000, 16'h7100, 8'd4, 4'hF, -1, 1);   // R2/R10 while busy

    // R2: wrong hardware line
    configure(4'h0, 16'h0400, 16'h0012, 8'd0, 4'd3);
    trig[5] = 1; @(negedge clk); trig = '0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd, "R2", "unselected trigger ignored", busy, 0);
    // R2: out-of-range select ignores all lines
    configure(4'h0, 16'h0400, 16'h0012, 8'd0, 4'd12);
    trig = '1; @(negedge clk); trig = '0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd, "R2", "select 12 disables hardware", busy, 0);
    chk(ptr0 == 16'h0400 && ptr1 == 16'h0012, "R10", "idle config load", ptr0, 16'h0400);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule